// File: doc/BRIEF.md
# GPIO Port with Atomic Set, Clear and Toggle Aliases

This block is a memory-mapped general-purpose I/O port of up to 32 lines. Software reaches it over a simple word-addressed register bus: an address, a write strobe, write data and combinational read data. On the pad side it takes an input vector and drives an output value vector and an output-enable vector.

The port holds an output register and a direction register. Either one can be written whole. Either one can also be changed in a single bus write through OR, AND and XOR alias addresses. Software can therefore set, clear or flip individual pins with no read-modify-write sequence that another agent could interrupt. Pad inputs pass through a multi-flop synchronizer before software reads them. A read-only capability word reports the configured width and synchronizer depth. Interrupt logic lives in a separate block.

Top module: `gpio_bitop_port`

## Requirements
- R1: After reset the output register and the direction register are zero, so oe_o and pad_o are all zero and every line is an input.
- R2: A write to address 1 replaces the output register with the write data. A read of address 1 returns it. With no write, the register holds its value.
- R3: A write to address 4 sets the output register to its previous value OR the write data.
- R4: A write to address 5 sets the output register to its previous value AND the write data. Writing the inverted mask clears the pins in that mask.
- R5: A write to address 6 flips every output bit whose write-data bit is 1 and leaves the other bits unchanged.
- R6: The direction register is written whole at address 2. It is combined by OR at address 8, by AND at address 9 and by XOR at address 10.
- R7: oe_o equals the direction register, where 1 means the line is driven. pad_o equals the output register.
- R8: A read of address 0 returns pad_i as seen through SYNC_STAGES flops. With SYNC_STAGES=2, a pad change made between two rising edges is not visible after the first of those edges and is visible after the second.
- R9: Read-data bits at and above WIDTH are zero for every address except 3. Writes to those bits have no effect.
- R10: A read of an alias address returns the register it modifies. Addresses 4, 5 and 6 return the output register. Addresses 8, 9 and 10 return the direction register.
- R11: Address 3 reads WIDTH in bits 7:0 and SYNC_STAGES in bits 11:8, with the other bits zero. Writes to addresses 0 and 3 change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | 1 | Write strobe |
| addr_i | input | 4 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| pad_i | input | WIDTH | Pad input levels |
| pad_o | output | WIDTH | Pad drive values |
| oe_o | output | WIDTH | Pad output enables |

## Verification
The bench builds the port with WIDTH=12 and SYNC_STAGES=2. The narrow width makes the zero-filled upper read bits visible. Writes of all ones then show that those bits are discarded, and the capability word takes a value the bench can predict. The depth of two lets the bench check the exact edge on which a pad change reaches the data register. Random sequences of plain and alias writes to both registers are compared against a bench model of the two registers.

// File: rtl/gpio_bitop_pkg.sv
package gpio_bitop_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] A_DATA    = 4'd0;
  localparam logic [ADDR_W-1:0] A_OUT     = 4'd1;
  localparam logic [ADDR_W-1:0] A_DIR     = 4'd2;
  localparam logic [ADDR_W-1:0] A_CAP     = 4'd3;
  localparam logic [ADDR_W-1:0] A_OUT_OR  = 4'd4;
  localparam logic [ADDR_W-1:0] A_OUT_AND = 4'd5;
  localparam logic [ADDR_W-1:0] A_OUT_XOR = 4'd6;
  localparam logic [ADDR_W-1:0] A_DIR_OR  = 4'd8;
  localparam logic [ADDR_W-1:0] A_DIR_AND = 4'd9;
  localparam logic [ADDR_W-1:0] A_DIR_XOR = 4'd10;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_WR,
    OP_OR,
    OP_AND,
    OP_XOR
  } bitop_e;

  function automatic bitop_e decode_op(
    input logic              we,
    input logic [ADDR_W-1:0] addr,
    input logic [ADDR_W-1:0] a_wr,
    input logic [ADDR_W-1:0] a_or,
    input logic [ADDR_W-1:0] a_and,
    input logic [ADDR_W-1:0] a_xor
  );
    bitop_e op;
    op = OP_NONE;
    if (we) begin
      if (addr == a_wr)       op = OP_WR;
      else if (addr == a_or)  op = OP_OR;
      else if (addr == a_and) op = OP_AND;
      else if (addr == a_xor) op = OP_XOR;
    end
    return op;
  endfunction
endpackage

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[0] <= '0;
        else         stg_q[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_bitop_reg.sv
module gpio_bitop_reg
  import gpio_bitop_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  bitop_e           op_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] q_d;

  always_comb begin
    unique case (op_i)
      OP_WR:   q_d = wdata_i;
      OP_OR:   q_d = q_o | wdata_i;
      OP_AND:  q_d = q_o & wdata_i;
      OP_XOR:  q_d = q_o ^ wdata_i;
      default: q_d = q_o;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= q_d;
  end
endmodule

// File: rtl/gpio_bitop_port.sv
module gpio_bitop_port
  import gpio_bitop_pkg::*;
#(
  parameter int WIDTH       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [WIDTH-1:0]  pad_i,
  output logic [WIDTH-1:0]  pad_o,
  output logic [WIDTH-1:0]  oe_o
);
  localparam logic [DATA_W-1:0] CAP_WORD =
    DATA_W'(WIDTH & 8'hff) | (DATA_W'(SYNC_STAGES & 4'hf) << 8);

  logic [WIDTH-1:0] out_q, dir_q, in_sync;
  bitop_e           out_op, dir_op;

  assign out_op = decode_op(we_i, addr_i, A_OUT, A_OUT_OR, A_OUT_AND, A_OUT_XOR);
  assign dir_op = decode_op(we_i, addr_i, A_DIR, A_DIR_OR, A_DIR_AND, A_DIR_XOR);

  gpio_bitop_reg #(.WIDTH(WIDTH)) u_out_reg (
    .clk_i, .rst_ni, .op_i(out_op), .wdata_i(wdata_i[WIDTH-1:0]), .q_o(out_q)
  );

  gpio_bitop_reg #(.WIDTH(WIDTH)) u_dir_reg (
    .clk_i, .rst_ni, .op_i(dir_op), .wdata_i(wdata_i[WIDTH-1:0]), .q_o(dir_q)
  );

  gpio_pad_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(pad_i), .q_o(in_sync)
  );

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_DATA:                              rdata_o[WIDTH-1:0] = in_sync;
      A_OUT, A_OUT_OR, A_OUT_AND, A_OUT_XOR: rdata_o[WIDTH-1:0] = out_q;
      A_DIR, A_DIR_OR, A_DIR_AND, A_DIR_XOR: rdata_o[WIDTH-1:0] = dir_q;
      A_CAP:                               rdata_o = CAP_WORD;
      default:                             rdata_o = '0;
    endcase
  end

  assign pad_o = out_q;
  assign oe_o  = dir_q;
endmodule

// File: rtl/gpio_bitop_port_chk.sv
module gpio_bitop_port_chk
  import gpio_bitop_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [WIDTH-1:0]  pad_o,
  input logic [WIDTH-1:0]  oe_o
);
  p_or_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_OUT_OR) |=> pad_o == ($past(pad_o) | $past(wdata_i[WIDTH-1:0])));

  p_and_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_OUT_AND) |=> pad_o == ($past(pad_o) & $past(wdata_i[WIDTH-1:0])));

  p_xor_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_OUT_XOR) |=> pad_o == ($past(pad_o) ^ $past(wdata_i[WIDTH-1:0])));

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ($stable(pad_o) && $stable(oe_o)));

  p_dir_or_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_DIR_OR) |=> oe_o == ($past(oe_o) | $past(wdata_i[WIDTH-1:0])));

  p_dir_and_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_DIR_AND) |=> oe_o == ($past(oe_o) & $past(wdata_i[WIDTH-1:0])));

  p_ro_write_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (addr_i == A_CAP || addr_i == A_DATA)) |=> ($stable(pad_o) && $stable(oe_o)));

  p_alias_rd_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == A_OUT_XOR) |-> rdata_o[WIDTH-1:0] == pad_o);

  if (WIDTH < DATA_W) begin : g_upper
    p_upper_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (addr_i != A_CAP) |-> rdata_o[DATA_W-1:WIDTH] == '0);
  end
endmodule

bind gpio_bitop_port gpio_bitop_port_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .rdata_o(rdata_o), .pad_o(pad_o), .oe_o(oe_o)
);

// File: tb/gpio_bitop_port_tb.sv
module gpio_bitop_port_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 12;
  localparam int SS = 2;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        we = 0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [W-1:0] pad_in = '0;
  logic [W-1:0] pad_out, oe;

  int checks = 0;
  int fails = 0;
  logic [W-1:0] m_out = '0;
  logic [W-1:0] m_dir = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_bitop_port #(.WIDTH(W), .SYNC_STAGES(SS)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .pad_i(pad_in), .pad_o(pad_out), .oe_o(oe)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1; addr = a; wdata = d;
    @(negedge clk);
    we = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  function automatic void model(input logic [3:0] a, input logic [W-1:0] d);
    case (a)
      4'd1:  m_out = d;
      4'd4:  m_out = m_out | d;
      4'd5:  m_out = m_out & d;
      4'd6:  m_out = m_out ^ d;
      4'd2:  m_dir = d;
      4'd8:  m_dir = m_dir | d;
      4'd9:  m_dir = m_dir & d;
      4'd10: m_dir = m_dir ^ d;
      default: ;
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [3:0] ops [8];
    ops = '{4'd1, 4'd4, 4'd5, 4'd6, 4'd2, 4'd8, 4'd9, 4'd10};
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    rd(4'd1, r); check("R1 out", r, 32'h0);
    rd(4'd2, r); check("R1 dir", r, 32'h0);
    check("R1 oe", {20'h0, oe}, 32'h0);
    check("R1 pad_o", {20'h0, pad_out}, 32'h0);

    // R2 plain write, R9 upper bits dropped
    wr(4'd1, 32'hFFFF_FFFF); model(4'd1, 12'hFFF);
    rd(4'd1, r); check("R9 out upper", r, 32'h0000_0FFF);
    wr(4'd1, 32'h0000_0A5C); model(4'd1, 12'hA5C);
    rd(4'd1, r); check("R2 plain write", r, 32'h0000_0A5C);
    // R3/R4/R5 directed
    wr(4'd4, 32'h0000_0003); model(4'd4, 12'h003);
    rd(4'd1, r); check("R3 or", r, 32'h0000_0A5F);
    wr(4'd5, ~32'h0000_0A00); model(4'd5, ~12'hA00);
    rd(4'd1, r); check("R4 and clear", r, 32'h0000_005F);
    wr(4'd6, 32'h0000_0F0F); model(4'd6, 12'hF0F);
    rd(4'd1, r); check("R5 xor", r, 32'h0000_0F50);
    // R10 alias reads
    rd(4'd4, r); check("R10 out_or read", r, 32'h0000_0F50);
    rd(4'd6, r); check("R10 out_xor read", r, 32'h0000_0F50);
    // R6 dir ops
    wr(4'd2, 32'h0000_00F0); model(4'd2, 12'h0F0);
    wr(4'd8, 32'h0000_0801); model(4'd8, 12'h801);
    rd(4'd9, r); check("R6 dir or / R10 dir alias", r, 32'h0000_08F1);
    wr(4'd9, ~32'h0000_0010); model(4'd9, ~12'h010);
    wr(4'd10, 32'h0000_0003); model(4'd10, 12'h003);
    rd(4'd2, r); check("R6 dir and/xor", r, 32'h0000_08E2);
    check("R7 oe", {20'h0, oe}, {20'h0, m_dir});
    check("R7 pad_o", {20'h0, pad_out}, {20'h0, m_out});
    // R11 capability and read-only writes
    rd(4'd3, r); check("R11 cap", r, 32'h0000_020C);
    wr(4'd3, 32'h0);
    rd(4'd3, r); check("R11 cap after write", r, 32'h0000_020C);
    wr(4'd0, 32'hFFFF_FFFF);
    rd(4'd1, r); check("R11 data write out", r, {20'h0, m_out});
    rd(4'd2, r); check("R11 data write dir", r, {20'h0, m_dir});

    // R8 synchronizer latency
    @(negedge clk); pad_in = 12'h5A3;
    @(negedge clk); rd(4'd0, r); check("R8 after one edge", r, 32'h0);
    @(negedge clk); rd(4'd0, r); check("R8 after two edges", r, 32'h0000_05A3);
    rd(4'd0, r); check("R9 data upper", r & 32'hFFFF_F000, 32'h0);

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [3:0]  a;
      logic [31:0] d;
      logic [W-1:0] p;
      a = ops[$urandom_range(0, 7)];
      d = $urandom();
      wr(a, d); model(a, d[W-1:0]);
      rd(4'd1, r); check("R2-R5 random out", r, {20'h0, m_out});
      rd(4'd2, r); check("R6 random dir", r, {20'h0, m_dir});
      check("R7 random pad_o", {20'h0, pad_out}, {20'h0, m_out});
      check("R7 random oe", {20'h0, oe}, {20'h0, m_dir});
      if (i % 20 == 0) begin
        p = W'($urandom());
        pad_in = p;
        @(negedge clk); @(negedge clk);
        rd(4'd0, r); check("R8 random data", r, {20'h0, p});
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule